// File: doc/BRIEF.md
# Repeat-Mode DMA Channel Controller

This block is one channel of a direct memory access engine that copies a block of data from a source area to a destination area with no processor help. Each transfer unit (one byte or one 16-bit halfword) takes two bus cycles: a read at the source pointer, then a write of the same data at the destination pointer. After each unit the pointers step forward or backward by the unit size, and the byte count falls by the unit size.

The channel runs only in repeat mode. Software loads a start source pointer, a start destination pointer and a byte count. Each value is kept twice: once in a working register and once in a reload copy. When the count runs out, the working registers reload from those copies and the block starts over. The enable bit stays set. In burst handling one request keeps the channel copying until it is stopped. In cycle-steal handling each request moves exactly one unit. Software stops the channel by writing the enable bit to 0, and an external active-low terminate input also stops it.

The memory side is a valid/ready bus. The channel raises `bus_valid` with the address, direction and write data. It holds all of them unchanged until the memory returns `bus_ready` in a cycle where `bus_valid` is high, so the memory can insert any number of wait states. That rule does not hold when a stop command arrives: `bus_valid` then drops in the next cycle.

Top module: `dma_rpt_chan`

## Requirements
- R1: After reset `bus_valid` and `dma_ack` are low and the channel is disabled.
- R2: Each unit is a read at the source pointer followed by a write of the read data to the destination pointer. The unit size is a halfword when control bit 0 is 1 (data on `bus_rdata`/`bus_wdata` [15:0], low byte at the even address) and a byte when it is 0 (data on bits [7:0]). `bus_size` is 1 for a halfword.
- R3: After each unit the source pointer moves by the unit size in bytes, forward or backward. Control bit 2 selects the source direction and control bit 3 the destination direction, with 1 meaning backward.
- R4: The count falls by the unit size after each unit. When a unit uses up the count, both pointers and the count reload the values software last wrote, and the enable bit stays set.
- R5: With burst handling (control bit 1 = 1), one request starts units back to back, and blocks repeat until the channel is stopped.
- R6: With cycle-steal handling (control bit 1 = 0), each one-cycle request on `dma_req` moves exactly one unit, and no unit starts without a request.
- R7: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_we` and `bus_wdata` stay unchanged in the next cycle, unless a stop occurs.
- R8: `dma_ack` is high for the whole unit, from the start of its read to the end of its write, and it is high whenever `bus_valid` is high.
- R9: `term_n` low ends any unit in progress, so that `bus_valid` is low one cycle later. It also clears the enable bit, so the channel stays idle after `term_n` returns high, even when new requests arrive.
- R10: Writing the control register with enable (bit 4) = 0 stops the channel in the same way.
- R11: With a byte count of 0, the channel starts no unit.
- R12: Registers are written through `reg_we`/`reg_sel`/`reg_wdata`. Select 0 is the source pointer, 1 the destination pointer, 2 the byte count and 3 the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 source, 1 destination, 2 count, 3 control) |
| reg_wdata | input | AW | Register write data |
| dma_req | input | 1 | Transfer request, sampled each cycle |
| term_n | input | 1 | Active-low forced stop |
| bus_valid | output | 1 | Bus cycle request |
| bus_ready | input | 1 | Bus cycle completion from memory |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Byte address |
| bus_size | output | 1 | 1 for halfword, 0 for byte |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| dma_ack | output | 1 | High while a unit is in progress |

## Verification
The assertions take for granted that the memory raises `bus_ready` only while `bus_valid` is high. They also assume that software rewrites the pointers, the count and the mode only while the channel is idle or disabled, that the count is a multiple of the unit size, and that a stop never lands in the same cycle as a bus completion. The bench keeps to these assumptions. Its memory model answers only pending cycles, after a programmable number of wait cycles. It reconfigures the channel only after a disable or terminate, with the bus idle. It picks counts of 6, 3, 4 and 0 to suit each unit size.

// File: rtl/dma_rpt_pkg.sv
package dma_rpt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_state_e;

  typedef struct packed {
    logic enable;
    logic dst_back;
    logic src_back;
    logic burst;
    logic unit16;
  } dma_mode_t;

  localparam int SEL_SRC  = 0;
  localparam int SEL_DST  = 1;
  localparam int SEL_CNT  = 2;
  localparam int SEL_CTRL = 3;
  localparam int MODE_W   = 5;
endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          reload,
  input  logic          backward,
  input  logic [1:0]    step_bytes,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] shadow_q;
  logic [AW-1:0] delta;

  assign delta = AW'(step_bytes);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr     <= '0;
      shadow_q <= '0;
    end else if (load) begin
      addr     <= load_val;
      shadow_q <= load_val;
    end else if (step) begin
      if (reload)        addr <= shadow_q;
      else if (backward) addr <= addr - delta;
      else               addr <= addr + delta;
    end
  end

  // R3
  fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload && !load && !backward) |=> (addr == $past(addr) + $past(delta)));
  // R3
  back_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload && !load && backward) |=> (addr == $past(addr) - $past(delta)));
  // R4
  ptr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && reload && !load) |=> (addr == $past(shadow_q)));
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_rpt_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          term_n,
  input  logic          unit_done,
  input  logic [1:0]    unit_bytes,
  output dma_mode_t     mode,
  output logic [CW-1:0] cnt,
  output logic          last_unit,
  output logic          abort
);
  logic [CW-1:0] cnt_shadow_q;
  logic          cnt_wr;
  logic          ctrl_wr;

  assign cnt_wr    = reg_we && (reg_sel == 2'(SEL_CNT));
  assign ctrl_wr   = reg_we && (reg_sel == 2'(SEL_CTRL));
  assign abort     = !term_n || (ctrl_wr && !reg_wdata[MODE_W-1]);
  assign last_unit = (cnt <= CW'(unit_bytes));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      cnt_shadow_q <= '0;
    end else if (cnt_wr) begin
      cnt          <= reg_wdata[CW-1:0];
      cnt_shadow_q <= reg_wdata[CW-1:0];
    end else if (unit_done) begin
      if (last_unit) cnt <= cnt_shadow_q;
      else           cnt <= cnt - CW'(unit_bytes);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
    end else begin
      if (ctrl_wr) mode <= dma_mode_t'(reg_wdata[MODE_W-1:0]);
      if (!term_n) mode.enable <= 1'b0;
    end
  end

  // R9
  term_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !term_n |=> !mode.enable);
  // R4
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && last_unit && !cnt_wr) |=> (cnt == $past(cnt_shadow_q)));
  // R4
  en_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && mode.enable && term_n && !ctrl_wr) |=> mode.enable);
endmodule

// File: rtl/dma_req_ctl.sv
module dma_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic burst,
  input  logic unit_done,
  input  logic abort,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  req_q <= 1'b0;
    else if (abort)              req_q <= 1'b0;
    else if (dma_req)            req_q <= 1'b1;
    else if (unit_done && !burst) req_q <= 1'b0;
  end

  // R6
  steal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !burst && !dma_req && !abort) |=> !req_q);
  // R5
  burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && burst && !abort) |=> req_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_rpt_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          abort,
  input  logic          unit16,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_size,
  output logic          dma_ack,
  output logic          unit_done,
  output logic [1:0]    unit_bytes
);
  seq_state_e    state_q;
  logic [DW-1:0] data_q;
  logic          size_q;
  logic          ack_q;

  assign bus_valid  = (state_q != ST_IDLE);
  assign bus_we     = (state_q == ST_WR);
  assign bus_addr   = (state_q == ST_WR) ? dst_addr : src_addr;
  assign bus_wdata  = data_q;
  assign bus_size   = size_q;
  assign dma_ack    = ack_q;
  assign unit_done  = (state_q == ST_WR) && bus_ready && !abort;
  assign unit_bytes = size_q ? 2'd2 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      size_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else if (abort) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q <= ST_RD;
          size_q  <= unit16;
          ack_q   <= 1'b1;
        end
        ST_RD: if (bus_ready) begin
          data_q  <= size_q ? bus_rdata : DW'(bus_rdata[7:0]);
          state_q <= ST_WR;
        end
        ST_WR: if (bus_ready) begin
          state_q <= ST_IDLE;
          ack_q   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !abort) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_ready && !abort) |=> (bus_valid && bus_we));
  // R8
  ack_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> dma_ack);
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!bus_valid && !dma_ack));
endmodule

// File: rtl/dma_rpt_chan.sv
module dma_rpt_chan
  import dma_rpt_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          dma_req,
  input  logic          term_n,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic          bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          dma_ack
);
  localparam int NPTR = 2;

  dma_mode_t     mode;
  logic [CW-1:0] cnt;
  logic          last_unit;
  logic          abort;
  logic          unit_done;
  logic [1:0]    unit_bytes;
  logic          req_q;
  logic          start_ok;
  logic [AW-1:0] ptr_addr [NPTR];

  assign start_ok = mode.enable && req_q && (cnt != '0);

  dma_ctrl_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .term_n(term_n), .unit_done(unit_done),
    .unit_bytes(unit_bytes), .mode(mode), .cnt(cnt),
    .last_unit(last_unit), .abort(abort)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam int SEL = (g == 0) ? SEL_SRC : SEL_DST;
    logic back;
    assign back = (g == 0) ? mode.src_back : mode.dst_back;
    dma_addr_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(reg_we && (reg_sel == 2'(SEL))), .load_val(reg_wdata),
      .step(unit_done), .reload(last_unit), .backward(back),
      .step_bytes(unit_bytes), .addr(ptr_addr[g])
    );
  end

  dma_req_ctl u_req (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .burst(mode.burst),
    .unit_done(unit_done), .abort(abort), .req_q(req_q)
  );

  dma_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .abort(abort),
    .unit16(mode.unit16), .src_addr(ptr_addr[0]), .dst_addr(ptr_addr[1]),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .dma_ack(dma_ack), .unit_done(unit_done),
    .unit_bytes(unit_bytes)
  );

  // R11
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == '0) && !bus_valid) |=> !bus_valid);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!bus_valid && !dma_ack));
endmodule

// File: tb/dma_rpt_chan_test.sv
module dma_rpt_chan_test;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          dma_req = 1'b0;
  logic          term_n = 1'b1;
  logic          bus_valid, bus_we, bus_size, dma_ack;
  logic          bus_ready;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int total = 0;
  int bad = 0;
  int waits = 0;
  int wcnt = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int hold_err = 0;
  int ack_err = 0;
  logic [7:0]  mem [256];
  logic [7:0]  wr_addr [256];
  logic [15:0] wr_data [256];
  logic [7:0]  rd_addr [256];
  logic [7:0]  a8;

  always #4 clk = ~clk;

  dma_rpt_chan #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dma_req(dma_req), .term_n(term_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_ack(dma_ack)
  );

  assign a8 = bus_addr[7:0];
  assign bus_rdata = bus_size ? {mem[8'(a8 + 8'd1)], mem[a8]} : {8'h00, mem[a8]};

  // memory model with programmable wait cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      wcnt <= 0;
    end else if (bus_valid && bus_ready) begin
      if (bus_we) begin
        mem[a8] <= bus_wdata[7:0];
        if (bus_size) mem[8'(a8 + 8'd1)] <= bus_wdata[15:8];
        wr_addr[wr_cnt % 256] <= a8;
        wr_data[wr_cnt % 256] <= bus_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_addr[rd_cnt % 256] <= a8;
        rd_cnt <= rd_cnt + 1;
      end
      bus_ready <= 1'b0;
      wcnt <= 0;
    end else if (bus_valid) begin
      if (wcnt >= waits) bus_ready <= 1'b1;
      else wcnt <= wcnt + 1;
    end else begin
      bus_ready <= 1'b0;
      wcnt <= 0;
    end
  end

  // monitors for R7 and R8
  logic          p_valid = 1'b0, p_ready = 1'b0, p_we = 1'b0, p_quiet = 1'b1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_wdata = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_valid && !p_ready && !p_quiet &&
          !(bus_valid && bus_addr == p_addr && bus_we == p_we && bus_wdata == p_wdata))
        hold_err++;
      if (bus_valid && !dma_ack) ack_err++;
    end
    p_valid = bus_valid; p_ready = bus_ready; p_we = bus_we;
    p_addr = bus_addr; p_wdata = bus_wdata;
    p_quiet = reg_we || !term_n || !rst_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int sel, input logic [AW-1:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); dma_req = 1'b1;
    @(negedge clk); dma_req = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    for (int i = 0; i < 2000 && wr_cnt < n; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] hw(input logic [7:0] a);
    return {mem[8'(a + 8'd1)], mem[a]};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(bus_valid == 1'b0, "R1 valid", 32'(bus_valid), 0);
    chk(dma_ack == 1'b0, "R1 ack", 32'(dma_ack), 0);
    pulse_req();
    idle(10);
    chk(wr_cnt == 0, "R1 disabled", wr_cnt, 0);
  endtask

  // 16-bit, both forward, burst, count 6
  task automatic t_burst();
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt; waits = 0;
    wr_reg(0, 24'h10); wr_reg(1, 24'h40); wr_reg(2, 24'd6);
    wr_reg(3, 24'h13);
    pulse_req();
    wait_writes(w0 + 7);
    wr_reg(3, 24'h00);
    idle(5);
    for (int k = 0; k < 7; k++) begin
      logic [7:0] ea, es;
      ea = 8'(8'h40 + 2 * (k % 3));
      es = 8'(8'h10 + 2 * (k % 3));
      chk(wr_addr[(w0 + k) % 256] == ea, "R3 R4 R5 burst dst", wr_addr[(w0 + k) % 256], ea);
      chk(rd_addr[(r0 + k) % 256] == es, "R3 R4 burst src", rd_addr[(r0 + k) % 256], es);
      chk(wr_data[(w0 + k) % 256] == hw(es), "R2 burst data", wr_data[(w0 + k) % 256], hw(es));
    end
    chk(bus_valid == 1'b0, "R10 stop valid", 32'(bus_valid), 0);
    w0 = wr_cnt;
    idle(20);
    chk(wr_cnt == w0, "R10 stays stopped", wr_cnt, w0);
  endtask

  // byte units, both backward, cycle-steal, count 3, wait states
  task automatic t_steal();
    int w0;
    w0 = wr_cnt; waits = 2;
    wr_reg(0, 24'h23); wr_reg(1, 24'h63); wr_reg(2, 24'd3);
    wr_reg(3, 24'h0C | 24'h10);
    idle(20);
    chk(wr_cnt == w0, "R6 no request no unit", wr_cnt, w0);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] ed, es;
      pulse_req();
      idle(30);
      ed = 8'(8'h63 - (i % 3));
      es = 8'(8'h23 - (i % 3));
      chk(wr_cnt == w0 + i + 1, "R6 one unit per request", wr_cnt, w0 + i + 1);
      chk(wr_addr[(w0 + i) % 256] == ed, "R3 R4 steal dst back", wr_addr[(w0 + i) % 256], ed);
      chk(wr_data[(w0 + i) % 256] == {8'h00, mem[es]}, "R2 byte data",
          wr_data[(w0 + i) % 256], {8'h00, mem[es]});
    end
    wr_reg(3, 24'h00);
  endtask

  // 16-bit, source forward, destination backward, burst, count 4
  task automatic t_mixed();
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt; waits = 1;
    wr_reg(0, 24'h80); wr_reg(1, 24'hA4); wr_reg(2, 24'd4);
    wr_reg(3, 24'h1B);
    pulse_req();
    wait_writes(w0 + 3);
    wr_reg(3, 24'h00);
    idle(5);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] ed, es;
      ed = (k == 1) ? 8'hA2 : 8'hA4;
      es = (k == 1) ? 8'h82 : 8'h80;
      chk(wr_addr[(w0 + k) % 256] == ed, "R3 dst backward", wr_addr[(w0 + k) % 256], ed);
      chk(rd_addr[(r0 + k) % 256] == es, "R3 src forward", rd_addr[(r0 + k) % 256], es);
    end
  endtask

  task automatic t_term();
    int w0;
    w0 = wr_cnt; waits = 3;
    wr_reg(0, 24'h10); wr_reg(1, 24'hC0); wr_reg(2, 24'd6);
    wr_reg(3, 24'h13);
    pulse_req();
    wait_writes(w0 + 2);
    idle(2);
    @(negedge clk); term_n = 1'b0;
    @(negedge clk);
    chk(bus_valid == 1'b0, "R9 valid drops", 32'(bus_valid), 0);
    chk(dma_ack == 1'b0, "R9 ack drops", 32'(dma_ack), 0);
    term_n = 1'b1;
    w0 = wr_cnt;
    idle(20);
    pulse_req();
    idle(20);
    chk(wr_cnt == w0, "R9 enable cleared", wr_cnt, w0);
  endtask

  task automatic t_zero();
    int w0;
    w0 = wr_cnt; waits = 0;
    wr_reg(0, 24'h10); wr_reg(1, 24'hE0); wr_reg(2, 24'd0);
    wr_reg(3, 24'h13);
    pulse_req();
    idle(20);
    chk(wr_cnt == w0, "R11 zero count", wr_cnt, w0);
    chk(bus_valid == 1'b0, "R11 idle", 32'(bus_valid), 0);
    wr_reg(3, 24'h00);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_burst();
    t_steal();
    t_mixed();
    t_term();
    t_zero();
    chk(hold_err == 0, "R7 bus hold", hold_err, 0);
    chk(ack_err == 0, "R8 ack during unit", ack_err, 0);
    chk(wr_cnt > 0, "R12 register writes start units", wr_cnt, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule